// File: doc/BRIEF.md
# Configurable CRC Engine with Output Folding

This block computes a cyclic redundancy check over a stream of bytes. The polynomial, the seed, the final-XOR value and the polynomial length (1 to 32 bits) are all programmable. A start pulse loads the seed and opens a frame. After that, one byte per clock is folded into the remainder, most significant bit first. A byte flagged as last closes the frame, and a one-cycle done pulse follows.

The remainder passes through a folding stage before it reaches the result port. The stage has four variants, selected by two control bits:

- **plain:** the remainder is passed through right-aligned.
- **bit reflection:** bits are reversed inside each occupied byte.
- **byte swap:** the order of the occupied bytes is reversed.
- **full reversal:** the bits are reversed across exactly the programmed length.

The folded value is XORed with the final-XOR register. The result port follows the current remainder combinationally, so it is valid while done is high and also straight after a start pulse.

Top module: `crc_fold_top`

## Requirements
- R1: After reset, crc_result is 0, done is 0 and busy is 0.
- R2: A write with cfg_we selects a register by cfg_addr: 0 polynomial, 1 seed, 2 final-XOR value, 3 control. The control register holds the length in bits 5:0, bit reflection in bit 8 and byte swap in bit 9. A length of 0 or above 32 is stored as 32.
- R3: A start pulse loads the seed, masked to the programmed length, into the remainder and raises busy. In the next cycle crc_result already shows that seed through the folding stage and the final XOR.
- R4: While busy, each byte with din_valid is shifted into the remainder MSB-first, one byte per clock. The polynomial is masked to the programmed length.
- R5: One cycle after a byte with din_last is accepted, done is high for exactly one cycle and busy is low.
- R6: With both control bits clear, the result is the remainder right-aligned, with every bit at or above the length zero.
- R7: With only bit reflection set, each of the ceil(length/8) low bytes is bit-reversed in place. For example, a 3-bit value gives S0 in bit 7, S1 in bit 6 and S2 in bit 5.
- R8: With only byte swap set, the order of the ceil(length/8) low bytes is reversed and the bits inside each byte are kept. A length of 8 or less therefore leaves the value unchanged.
- R9: With both control bits set, the remainder is bit-reversed across exactly the programmed length. S0 lands in bit length-1 and S(length-1) lands in bit 0.
- R10: crc_result equals the folded value XOR the full 32-bit final-XOR register.
- R11: Configuration writes while busy have no effect. Bytes presented while not busy have no effect on the remainder or on done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Loads the seed and opens a frame |
| din_valid | input | 1 | Byte strobe |
| din | input | 8 | Data byte |
| din_last | input | 1 | Marks the final byte of a frame |
| crc_result | output | 32 | Folded and XORed checksum |
| done | output | 1 | One-cycle pulse after the last byte |
| busy | output | 1 | Frame in progress |

## Verification
Known check strings run through 8-bit and 32-bit polynomials, which confirms the shift direction and the masking of the polynomial. A fixed 21-bit seed, read straight after start under each folding mode, separates per-byte reflection, byte swapping and full-length reversal, since each of these gives a distinct literal value. A 3-bit seed covers sub-byte alignment, and writes of length 0 and 40 cover the clamp. Random frames with random lengths, polynomials, modes and final-XOR values then cross every mode with odd lengths that do not fill a whole byte.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;
  typedef enum logic [1:0] {
    CFG_POLY = 2'd0,
    CFG_SEED = 2'd1,
    CFG_FXOR = 2'd2,
    CFG_CTRL = 2'd3
  } cfg_sel_e;

  // encoding is {byte_swap, bit_reflect}
  typedef enum logic [1:0] {
    FOLD_PLAIN  = 2'b00,
    FOLD_BITREV = 2'b01,
    FOLD_BSWAP  = 2'b10,
    FOLD_FULL   = 2'b11
  } fold_mode_e;
endpackage

// File: rtl/crc_fold_cfg.sv
module crc_fold_cfg #(
  parameter int CRC_W    = 32,
  parameter int LEN_W    = 6,
  parameter int REFL_BIT = 8,
  parameter int SWAP_BIT = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    busy,
  input  logic                    we,
  input  logic [1:0]              addr,
  input  logic [CRC_W-1:0]        wdata,
  output logic [CRC_W-1:0]        poly,
  output logic [CRC_W-1:0]        seed,
  output logic [CRC_W-1:0]        fxor,
  output logic [CRC_W-1:0]        mask,
  output logic [LEN_W-1:0]        len,
  output crc_fold_pkg::fold_mode_e mode
);
  import crc_fold_pkg::*;

  logic [CRC_W-1:0] poly_q, seed_q, fxor_q;
  logic [LEN_W-1:0] len_q;
  fold_mode_e       mode_q;
  logic [LEN_W-1:0] len_req;
  logic             len_ok;
  logic             wr_ok;
  logic             unused_bits;

  assign len_req     = wdata[LEN_W-1:0];
  assign len_ok      = (len_req != '0) && (len_req <= LEN_W'(CRC_W));
  assign wr_ok       = we && !busy;
  assign unused_bits = ^{wdata[CRC_W-1:SWAP_BIT+1], wdata[REFL_BIT-1:LEN_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      poly_q <= '0;
      seed_q <= '0;
      fxor_q <= '0;
      len_q  <= LEN_W'(CRC_W);
      mode_q <= FOLD_PLAIN;
    end else if (wr_ok) begin
      case (cfg_sel_e'(addr))
        CFG_POLY: poly_q <= wdata;
        CFG_SEED: seed_q <= wdata;
        CFG_FXOR: fxor_q <= wdata;
        CFG_CTRL: begin
          len_q  <= len_ok ? len_req : LEN_W'(CRC_W);
          mode_q <= fold_mode_e'({wdata[SWAP_BIT], wdata[REFL_BIT]});
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < CRC_W; i++) begin : g_mask
    assign mask[i] = (LEN_W'(i) < len_q);
  end

  assign poly = poly_q & mask;
  assign seed = seed_q & mask;
  assign fxor = fxor_q;
  assign len  = len_q;
  assign mode = mode_q;

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && we) |=> ($stable(poly_q) && $stable(seed_q) && $stable(fxor_q)
                      && $stable(len_q) && $stable(mode_q)));

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    (len_q != '0) && (len_q <= LEN_W'(CRC_W)));
endmodule

// File: rtl/crc_fold_step.sv
module crc_fold_step #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 6
) (
  input  logic [CRC_W-1:0]  rem,
  input  logic [CRC_W-1:0]  poly,
  input  logic [CRC_W-1:0]  mask,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  nxt
);
  localparam int IDX_W = $clog2(CRC_W);

  logic [IDX_W-1:0] top_idx;
  assign top_idx = IDX_W'(len - LEN_W'(1));

  always_comb begin
    logic [CRC_W-1:0] r;
    logic             fb;
    r = rem;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb = r[top_idx] ^ data[b];
      r  = ((r << 1) & mask) ^ (fb ? poly : '0);
    end
    nxt = r;
  end
endmodule

// File: rtl/crc_fold_out.sv
module crc_fold_out #(
  parameter int CRC_W = 32,
  parameter int LEN_W = 6
) (
  input  logic [CRC_W-1:0]         s,
  input  logic [LEN_W-1:0]         len,
  input  crc_fold_pkg::fold_mode_e mode,
  output logic [CRC_W-1:0]         folded
);
  import crc_fold_pkg::*;

  localparam int NB   = CRC_W / 8;
  localparam int SH_W = $clog2(CRC_W + 1);

  logic [CRC_W-1:0] bit_rev, byte_rev, in_byte_rev;
  logic [LEN_W-1:0] nbytes;
  logic [SH_W-1:0]  full_sh, swap_sh;

  for (genvar i = 0; i < CRC_W; i++) begin : g_brev
    assign bit_rev[i] = s[CRC_W-1-i];
  end

  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign byte_rev[8*k +: 8] = s[8*(NB-1-k) +: 8];
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign in_byte_rev[8*k + j] = s[8*k + 7 - j];
    end
  end

  assign nbytes  = (len + LEN_W'(7)) >> 3;
  assign full_sh = SH_W'(CRC_W) - SH_W'(len);
  assign swap_sh = SH_W'(CRC_W) - SH_W'({nbytes, 3'b000});

  always_comb begin
    case (mode)
      FOLD_PLAIN:  folded = s;
      FOLD_BITREV: folded = in_byte_rev;
      FOLD_BSWAP:  folded = byte_rev >> swap_sh;
      FOLD_FULL:   folded = bit_rev >> full_sh;
      default:     folded = s;
    endcase
  end
endmodule

// File: rtl/crc_fold_top.sv
module crc_fold_top #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CRC_W-1:0]  cfg_wdata,
  input  logic              start,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din,
  input  logic              din_last,
  output logic [CRC_W-1:0]  crc_result,
  output logic              done,
  output logic              busy
);
  import crc_fold_pkg::*;

  localparam int LEN_W = $clog2(CRC_W) + 1;

  logic [CRC_W-1:0] poly, seed, fxor, mask;
  logic [LEN_W-1:0] len;
  fold_mode_e       mode;
  logic [CRC_W-1:0] rem_q, rem_nxt, folded;
  logic             active_q, done_q;

  crc_fold_cfg #(.CRC_W(CRC_W), .LEN_W(LEN_W)) cfg_i (
    .clk(clk), .rst(rst), .busy(active_q), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .poly(poly), .seed(seed), .fxor(fxor), .mask(mask),
    .len(len), .mode(mode)
  );

  crc_fold_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) step_i (
    .rem(rem_q), .poly(poly), .mask(mask), .len(len), .data(din), .nxt(rem_nxt)
  );

  crc_fold_out #(.CRC_W(CRC_W), .LEN_W(LEN_W)) out_i (
    .s(rem_q), .len(len), .mode(mode), .folded(folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q    <= seed;
        active_q <= 1'b1;
      end else if (active_q && din_valid) begin
        rem_q <= rem_nxt;
        if (din_last) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign crc_result = folded ^ fxor;
  assign done       = done_q;
  assign busy       = active_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !active_q);

  // R4
  rem_span_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> ((rem_q & ~mask) == '0));

  // R6
  fold_span_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && (mode == FOLD_PLAIN || mode == FOLD_FULL)) |-> ((folded & ~mask) == '0));

  // R11
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !start && din_valid) |=> ($stable(rem_q) && !done_q));
endmodule

// File: tb/crc_fold_top_tb_top.sv
module crc_fold_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        start, din_valid, din_last;
  logic [7:0]  din;
  logic [31:0] crc_result;
  logic        done, busy;

  always #10 clk = ~clk;

  crc_fold_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .din_valid(din_valid), .din(din), .din_last(din_last),
    .crc_result(crc_result), .done(done), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0]  frame_b [16];
  logic [31:0] m_poly, m_seed, m_fxor;
  int          m_len;
  bit          m_refl, m_swap;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clamp_len(input int l);
    return (l < 1 || l > 32) ? 32 : l;
  endfunction

  function automatic logic [31:0] mask_of(input int l);
    return (l >= 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 32'h1);
  endfunction

  function automatic logic [31:0] crc_ref(input logic [31:0] sd, input logic [31:0] py,
                                          input int l, input int n);
    logic [31:0] mk = mask_of(l);
    logic [31:0] r  = sd & mk;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        bit top = r[l-1] ^ frame_b[i][b];
        r = (r << 1) & mk;
        if (top) r = r ^ (py & mk);
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] fold_ref(input logic [31:0] s, input int l,
                                           input bit refl, input bit swap);
    logic [31:0] o = '0;
    int nb = (l + 7) / 8;
    for (int i = 0; i < l; i++) begin
      int k = i / 8;
      int j = i % 8;
      if (!refl && !swap)     o[i] = s[i];
      else if (refl && !swap) o[8*k + 7 - j] = s[i];
      else if (!refl && swap) o[8*(nb-1-k) + j] = s[i];
      else                    o[l-1-i] = s[i];
    end
    return o;
  endfunction

  function automatic logic [31:0] ctrl_word(input int l, input bit refl, input bit swap);
    return {22'd0, swap, refl, 2'd0, 6'(l)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] py, input logic [31:0] sd, input logic [31:0] fx,
                       input int l, input bit refl, input bit swap);
    wr(2'd0, py); wr(2'd1, sd); wr(2'd2, fx); wr(2'd3, ctrl_word(l, refl, swap));
    m_poly = py; m_seed = sd; m_fxor = fx; m_len = clamp_len(l); m_refl = refl; m_swap = swap;
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", {31'd0, busy}, 32'd1);
  endtask

  task automatic feed(input int n, input logic [31:0] exp, input string req);
    for (int i = 0; i < n; i++) begin
      din_valid = 1'b1; din = frame_b[i]; din_last = (i == n - 1);
      @(negedge clk);
    end
    din_valid = 1'b0; din_last = 1'b0;
    chk("R5 done high", {31'd0, done}, 32'd1);
    chk("R5 busy low", {31'd0, busy}, 32'd0);
    chk(req, crc_result, exp);
    @(negedge clk);
    chk("R5 done single", {31'd0, done}, 32'd0);
  endtask

  function automatic logic [31:0] model_exp(input int n);
    return fold_ref(crc_ref(m_seed, m_poly, m_len, n), m_len, m_refl, m_swap) ^ m_fxor;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned sd0 = $urandom(32'd20240611);
    logic [31:0] hold;
    rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    start = 0; din_valid = 0; din_last = 0; din = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 result", crc_result, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);

    // R4 known check strings "123456789"
    for (int i = 0; i < 9; i++) frame_b[i] = 8'h31 + 8'(i);
    setup(32'h04C1_1DB7, 32'hFFFF_FFFF, 32'd0, 32, 0, 0);
    do_start();
    feed(9, 32'h0376_E6E7, "R4 crc32 check");
    setup(32'h0000_0107, 32'd0, 32'd0, 8, 0, 0);
    do_start();
    feed(9, 32'h0000_00F4, "R4 crc8 masked poly");

    // R6..R9 literal folds of a 21-bit seed read right after start
    frame_b[0] = 8'h00;
    setup(32'h0010_2030, 32'h0012_345, 32'd0, 21, 0, 0);
    do_start(); chk("R6 plain 21", crc_result, 32'h0001_2345); feed(1, model_exp(1), "R6 frame");
    setup(32'h0010_2030, 32'h0001_2345, 32'd0, 21, 1, 0);
    do_start(); chk("R7 refl 21", crc_result, 32'h0080_C4A2); feed(1, model_exp(1), "R7 frame");
    setup(32'h0010_2030, 32'h0001_2345, 32'd0, 21, 0, 1);
    do_start(); chk("R8 swap 21", crc_result, 32'h0045_2301); feed(1, model_exp(1), "R8 frame");
    setup(32'h0010_2030, 32'h0001_2345, 32'd0, 21, 1, 1);
    do_start(); chk("R9 full 21", crc_result, 32'h0014_5890); feed(1, model_exp(1), "R9 frame");
    setup(32'h5, 32'h3, 32'd0, 3, 1, 0);
    do_start(); chk("R7 refl 3", crc_result, 32'h0000_00C0); feed(1, model_exp(1), "R7 frame3");
    setup(32'h5, 32'h3, 32'd0, 3, 0, 1);
    do_start(); chk("R8 swap short", crc_result, 32'h0000_0003); feed(1, model_exp(1), "R8 frame3");
    setup(32'h5, 32'h3, 32'd0, 3, 1, 1);
    do_start(); chk("R9 full 3", crc_result, 32'h0000_0006); feed(1, model_exp(1), "R9 frame3");

    // R10 final XOR over all 32 bits
    setup(32'h0010_2030, 32'h0001_2345, 32'h00FF_00FF, 21, 0, 0);
    do_start(); chk("R10 fxor", crc_result, 32'h00FE_23BA); feed(1, model_exp(1), "R10 frame");

    // R2 clamp and R3 seed masking
    setup(32'h1, 32'hFFFF_FFFF, 32'd0, 0, 0, 0);
    do_start(); chk("R2 len0 clamp", crc_result, 32'hFFFF_FFFF); feed(1, model_exp(1), "R2 frame0");
    setup(32'h1, 32'hFFFF_FFFF, 32'd0, 40, 0, 0);
    do_start(); chk("R2 len40 clamp", crc_result, 32'hFFFF_FFFF); feed(1, model_exp(1), "R2 frame40");
    setup(32'h1, 32'hFFFF_FFFF, 32'd0, 8, 0, 0);
    do_start(); chk("R3 seed masked", crc_result, 32'h0000_00FF); feed(1, model_exp(1), "R3 frame8");

    // R11 config write during a frame is dropped
    setup(32'h0000_8005, 32'h0000_FFFF, 32'h0000_1234, 16, 0, 0);
    frame_b[0] = 8'hA5; frame_b[1] = 8'h3C;
    do_start();
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd3, ctrl_word(5, 1, 1));
    feed(2, model_exp(2), "R11 cfg ignored while busy");

    // R11 byte while idle is dropped
    hold = crc_result;
    din_valid = 1'b1; din = 8'h5A; din_last = 1'b1;
    @(negedge clk);
    din_valid = 1'b0; din_last = 1'b0;
    chk("R11 idle byte result", crc_result, hold);
    chk("R11 idle byte done", {31'd0, done}, 32'd0);

    // random frames across all modes and lengths
    for (int t = 0; t < 80; t++) begin
      int l = $urandom_range(1, 40);
      int n = $urandom_range(1, 12);
      bit rf = 1'($urandom_range(0, 1));
      bit sw = 1'($urandom_range(0, 1));
      for (int i = 0; i < n; i++) frame_b[i] = 8'($urandom);
      setup($urandom, $urandom, $urandom, l, rf, sw);
      do_start();
      chk("R3 random seed view", crc_result,
          fold_ref(m_seed & mask_of(m_len), m_len, m_refl, m_swap) ^ m_fxor);
      feed(n, model_exp(n), "R4 random frame");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule